// File: doc/BRIEF.md
# Prioritized Nested Interrupt Controller

This block gathers service requests from a parameterized set of interrupt nodes and tells the CPU which node to take next. Each node holds a pending flag, an enable flag and a four-bit priority. Among enabled, pending nodes with a non-zero priority, the one with the highest priority wins. Ties go to the lower node index. The winner is offered to the CPU only when its priority is strictly above the level of the service now running.

A request is raised with the winning node's index, its level and a vector address. The vector address is a programmable base plus the node index times four. When the CPU accepts the request with an acknowledge strobe, the running level is saved on an internal stack and the granted level becomes current. A return strobe restores the saved level. This allows nesting up to the number of priority levels.

Software reaches every node and the vector base through one register port. Writing a node's pending flag raises or drops a request from code. This lets nodes with no peripheral attached serve as software interrupts.

Top module: `nested_irq_ctrl`

## Requirements
- R1: A node whose enable bit is 0 is never offered, even while its pending flag is set.
- R2: A one-cycle pulse on `hw_req[i]` sets the pending flag of node i at the next clock edge.
- R3: `irq_valid` is 1 only when the best candidate's level is strictly greater than `cur_level`; a candidate at or below the current level is held back.
- R4: `irq_vector` equals the base register plus the winning node index shifted left by 2 bits, modulo 2^16.
- R5: Register map: an address with bit 3 clear selects node `reg_addr[2:0]`, whose word has bit 0 = pending, bit 1 = enable, bits 7:4 = priority level, and all other bits read 0. An address with bit 3 set selects the 16-bit vector base. Writes take effect at the clock edge, and reads are combinational. Writing 0 to bit 0 withdraws a pending request.
- R6: A node at priority level 0 is never offered.
- R7: When several candidates share the highest level, the lowest-numbered node is offered.
- R8: An `irq_ack` while `irq_valid` is 1 clears the offered node's pending flag and makes its level current at the next edge. An `irq_ack` while `irq_valid` is 0 has no effect.
- R9: `irq_ret` restores the level that was current before the most recent accepted acknowledge, across several nesting steps.
- R10: `irq_ret` with no service in progress leaves `cur_level` at 0.
- R11: When `irq_ack` and `irq_ret` are high in the same cycle, only the return is performed: the pending flag is kept and no level is pushed.
- R12: A `hw_req` pulse on the node being acknowledged in the same cycle leaves that node's pending flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_req | input | 8 | Per-node request pulses from sources |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| irq_ack | input | 1 | CPU accepts the offered request |
| irq_ret | input | 1 | CPU returns from the current service |
| irq_valid | output | 1 | A request is offered to the CPU |
| irq_node | output | 3 | Index of the offered node |
| irq_level | output | 4 | Priority of the offered node |
| irq_vector | output | 16 | Vector address of the offered node |
| cur_level | output | 4 | Level of the service in progress (0 = none) |

## Verification
All state changes land at the first clock edge after a write, `hw_req` pulse, acknowledge or return. The offer outputs and `cur_level` follow those registers with no further delay, so every result is due one cycle after its stimulus. Reads of `reg_rdata` are combinational and can be checked in the same cycle as the address. The bench drives inputs on the falling edge and samples shortly after the next falling edge, which is half a cycle after the edge that commits the change. That way each check sees exactly one committed step.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int LVL_W     = 4;
    localparam int LEVELS    = 1 << LVL_W;
    localparam int DATA_W    = 16;
    localparam int VEC_SH    = 2;
    localparam int F_PEND    = 0;
    localparam int F_EN      = 1;
    localparam int F_LVL_LSB = 4;

    typedef struct packed {
        logic [LVL_W-1:0] lvl;
        logic             en;
        logic             pend;
    } node_ctrl_t;

    function automatic logic [DATA_W-1:0] pack_ctrl(node_ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[F_PEND] = c.pend;
        w[F_EN]   = c.en;
        w[F_LVL_LSB +: LVL_W] = c.lvl;
        return w;
    endfunction

endpackage

// File: rtl/irq_node_bank.sv
module irq_node_bank
    import irq_pkg::*;
#(
    parameter int N_NODES = 8,
    localparam int IDX_W  = $clog2(N_NODES)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [N_NODES-1:0]           hw_req,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [DATA_W-1:0]            wdata,
    input  logic                         clr_en,
    input  logic [IDX_W-1:0]             clr_idx,
    output node_ctrl_t [N_NODES-1:0]     nodes
);

    for (genvar g = 0; g < N_NODES; g++) begin : g_node
        logic hit_wr;
        logic hit_clr;
        logic pend_base;

        assign hit_wr  = wr_en  && (wr_idx  == IDX_W'(g));
        assign hit_clr = clr_en && (clr_idx == IDX_W'(g));

        always_comb begin
            if (hit_clr)
                pend_base = 1'b0;
            else if (hit_wr)
                pend_base = wdata[F_PEND];
            else
                pend_base = nodes[g].pend;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                nodes[g] <= '0;
            end else begin
                if (hit_wr) begin
                    nodes[g].en  <= wdata[F_EN];
                    nodes[g].lvl <= wdata[F_LVL_LSB +: LVL_W];
                end
                nodes[g].pend <= hw_req[g] | pend_base;
            end
        end
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int N_NODES = 8,
    localparam int IDX_W  = $clog2(N_NODES)
) (
    input  node_ctrl_t [N_NODES-1:0] nodes,
    output logic                     found,
    output logic [IDX_W-1:0]         win_idx,
    output logic [LVL_W-1:0]         win_lvl
);

    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        win_lvl = '0;
        for (int i = 0; i < N_NODES; i++) begin
            if (nodes[i].pend && nodes[i].en && (nodes[i].lvl > win_lvl)) begin
                found   = 1'b1;
                win_idx = IDX_W'(i);
                win_lvl = nodes[i].lvl;
            end
        end
    end

endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack
    import irq_pkg::*;
#(
    parameter int DEPTH    = LEVELS,
    localparam int PTR_W   = $clog2(DEPTH),
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [LVL_W-1:0]  push_lvl,
    input  logic              pop,
    output logic [LVL_W-1:0]  cur_lvl,
    output logic [CNT_W-1:0]  depth
);

    logic [LVL_W-1:0] mem [DEPTH];
    logic             do_push;
    logic             do_pop;
    logic [CNT_W-1:0] depth_dec;

    assign do_pop    = pop && (depth != '0);
    assign do_push   = push && !pop && (depth != CNT_W'(DEPTH));
    assign depth_dec = depth - CNT_W'(1);

    always_ff @(posedge clk) begin
        if (do_push)
            mem[depth[PTR_W-1:0]] <= cur_lvl;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_lvl <= '0;
            depth   <= '0;
        end else if (do_pop) begin
            cur_lvl <= mem[depth_dec[PTR_W-1:0]];
            depth   <= depth_dec;
        end else if (do_push) begin
            cur_lvl <= push_lvl;
            depth   <= depth + CNT_W'(1);
        end
    end

endmodule

// File: rtl/nested_irq_ctrl.sv
module nested_irq_ctrl
    import irq_pkg::*;
#(
    parameter int N_NODES  = 8,
    localparam int IDX_W   = $clog2(N_NODES),
    localparam int ADDR_W  = IDX_W + 1,
    localparam int CNT_W   = $clog2(LEVELS + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_NODES-1:0]   hw_req,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic                 irq_ack,
    input  logic                 irq_ret,
    output logic                 irq_valid,
    output logic [IDX_W-1:0]     irq_node,
    output logic [LVL_W-1:0]     irq_level,
    output logic [DATA_W-1:0]    irq_vector,
    output logic [LVL_W-1:0]     cur_level
);

    node_ctrl_t [N_NODES-1:0] nodes;
    logic [DATA_W-1:0]        base_q;
    logic                     sel_base;
    logic                     found;
    logic                     take;
    logic [N_NODES-1:0]       pend_flags;
    logic [CNT_W-1:0]         stack_depth;

    assign sel_base = reg_addr[ADDR_W-1];
    assign take     = irq_ack && irq_valid && !irq_ret;

    always_ff @(posedge clk) begin
        if (rst)
            base_q <= '0;
        else if (reg_we && sel_base)
            base_q <= reg_wdata;
    end

    irq_node_bank #(.N_NODES(N_NODES)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .hw_req  (hw_req),
        .wr_en   (reg_we && !sel_base),
        .wr_idx  (reg_addr[IDX_W-1:0]),
        .wdata   (reg_wdata),
        .clr_en  (take),
        .clr_idx (irq_node),
        .nodes   (nodes)
    );

    irq_arbiter #(.N_NODES(N_NODES)) u_arb (
        .nodes   (nodes),
        .found   (found),
        .win_idx (irq_node),
        .win_lvl (irq_level)
    );

    irq_level_stack #(.DEPTH(LEVELS)) u_stack (
        .clk      (clk),
        .rst      (rst),
        .push     (take),
        .push_lvl (irq_level),
        .pop      (irq_ret),
        .cur_lvl  (cur_level),
        .depth    (stack_depth)
    );

    assign irq_valid  = found && (irq_level > cur_level);
    assign irq_vector = base_q + (DATA_W'(irq_node) << VEC_SH);

    for (genvar g = 0; g < N_NODES; g++) begin : g_flags
        assign pend_flags[g] = nodes[g].pend;
    end

    always_comb begin
        if (sel_base)
            reg_rdata = base_q;
        else
            reg_rdata = pack_ctrl(nodes[reg_addr[IDX_W-1:0]]);
    end

endmodule

// File: rtl/nested_irq_ctrl_chk.sv
module nested_irq_ctrl_chk
    import irq_pkg::*;
#(
    parameter int N_NODES = 8,
    localparam int IDX_W  = $clog2(N_NODES),
    localparam int CNT_W  = $clog2(LEVELS + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic               irq_ack,
    input logic               irq_ret,
    input logic               irq_valid,
    input logic [IDX_W-1:0]   irq_node,
    input logic [LVL_W-1:0]   irq_level,
    input logic [LVL_W-1:0]   cur_level,
    input logic [N_NODES-1:0] hw_req,
    input logic [N_NODES-1:0] pend_flags,
    input logic [CNT_W-1:0]   stack_depth
);

    a_r3_offer_above_current: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> (irq_level > cur_level));

    a_r6_level_zero_silent: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> (irq_level != '0));

    a_r8_ack_sets_level: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && irq_valid && !irq_ret) |=> (cur_level == $past(irq_level)));

    a_r8_ack_clears_flag: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && irq_valid && !irq_ret && !hw_req[irq_node])
        |=> !pend_flags[$past(irq_node)]);

    a_r9_return_pops: assert property (@(posedge clk) disable iff (rst)
        (irq_ret && stack_depth != '0) |=> (stack_depth == $past(stack_depth) - CNT_W'(1)));

    a_r10_empty_return_idle: assert property (@(posedge clk) disable iff (rst)
        (irq_ret && stack_depth == '0) |=> (cur_level == '0));

    a_r11_ret_wins: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && irq_ret) |=> (stack_depth != ($past(stack_depth) + CNT_W'(1))));

endmodule

bind nested_irq_ctrl nested_irq_ctrl_chk #(.N_NODES(N_NODES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .irq_ack     (irq_ack),
    .irq_ret     (irq_ret),
    .irq_valid   (irq_valid),
    .irq_node    (irq_node),
    .irq_level   (irq_level),
    .cur_level   (cur_level),
    .hw_req      (hw_req),
    .pend_flags  (pend_flags),
    .stack_depth (stack_depth)
);

// File: tb/sim_nested_irq_ctrl.sv
`timescale 1ns/1ps
module sim_nested_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  hw_req;
    logic        reg_we;
    logic [3:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic        irq_ack;
    logic        irq_ret;
    logic        irq_valid;
    logic [2:0]  irq_node;
    logic [3:0]  irq_level;
    logic [15:0] irq_vector;
    logic [3:0]  cur_level;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    nested_irq_ctrl u0 (
        .clk(clk), .rst(rst), .hw_req(hw_req), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_valid(irq_valid),
        .irq_node(irq_node), .irq_level(irq_level), .irq_vector(irq_vector),
        .cur_level(cur_level)
    );

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // drive on a falling edge, commit on the rising edge, settle at next fall
    task automatic wr(int a, int d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = 16'(d);
        @(negedge clk);
        reg_we = 1'b0;
        #1;
    endtask

    task automatic rd(int a, output int d);
        reg_addr = 4'(a);
        #1;
        d = int'(reg_rdata);
    endtask

    task automatic strobe(logic a, logic r, logic [7:0] h);
        @(negedge clk);
        irq_ack = a; irq_ret = r; hw_req = h;
        @(negedge clk);
        irq_ack = 1'b0; irq_ret = 1'b0; hw_req = '0;
        #1;
    endtask

    task automatic expect_offer(string tag, logic v, int node, int lvl);
        chk({tag, " valid"}, int'(irq_valid), int'(v));
        if (v) begin
            chk({tag, " node"}, int'(irq_node), node);
            chk({tag, " level"}, int'(irq_level), lvl);
        end
    endtask

    task automatic t_reset();
        int d;
        chk("R3 reset valid", int'(irq_valid), 0);
        chk("R9 reset cur_level", int'(cur_level), 0);
        rd(0, d); chk("R5 reset node0", d, 0);
        rd(8, d); chk("R5 reset base", d, 0);
    endtask

    task automatic t_vector();
        int d;
        wr(8, 'h0100);
        wr(3, 'h53);
        expect_offer("R4 sw raise", 1'b1, 3, 5);
        chk("R4 vector", int'(irq_vector), 'h010C);
        rd(3, d); chk("R5 readback node3", d, 'h53);
        rd(8, d); chk("R5 readback base", d, 'h0100);
    endtask

    task automatic t_filters();
        int d;
        wr(2, 'h71);
        expect_offer("R1 disabled node", 1'b1, 3, 5);
        rd(2, d); chk("R5 readback node2", d, 'h71);
        wr(1, 'h03);
        expect_offer("R6 level zero", 1'b1, 3, 5);
        wr(5, 'h53);
        expect_offer("R7 tie low index", 1'b1, 3, 5);
    endtask

    task automatic t_ack();
        int d;
        strobe(1'b1, 1'b0, '0);
        chk("R8 cur after ack", int'(cur_level), 5);
        rd(3, d); chk("R8 flag cleared", d, 'h52);
        expect_offer("R3 equal level held", 1'b0, 0, 0);
    endtask

    task automatic t_hw_nest();
        wr(6, 'h92);
        expect_offer("R2 before pulse", 1'b0, 0, 0);
        strobe(1'b0, 1'b0, 8'h40);
        expect_offer("R2 hw pulse", 1'b1, 6, 9);
        chk("R4 vector node6", int'(irq_vector), 'h0118);
        strobe(1'b1, 1'b0, '0);
        chk("R3 nested cur", int'(cur_level), 9);
    endtask

    task automatic t_returns();
        strobe(1'b0, 1'b1, '0);
        chk("R9 first return", int'(cur_level), 5);
        expect_offer("R9 held at 5", 1'b0, 0, 0);
        strobe(1'b0, 1'b1, '0);
        chk("R9 second return", int'(cur_level), 0);
        expect_offer("R9 node5 offered", 1'b1, 5, 5);
    endtask

    task automatic t_empty();
        int d;
        strobe(1'b1, 1'b0, '0);
        chk("R8 ack node5", int'(cur_level), 5);
        rd(5, d); chk("R8 node5 cleared", d, 'h52);
        strobe(1'b0, 1'b1, '0);
        strobe(1'b0, 1'b1, '0);
        chk("R10 empty return", int'(cur_level), 0);
        expect_offer("R10 nothing pending", 1'b0, 0, 0);
        strobe(1'b1, 1'b0, '0);
        chk("R8 ack without offer", int'(cur_level), 0);
    endtask

    task automatic t_same_cycle();
        int d;
        wr(4, 'h33);
        expect_offer("R11 node4", 1'b1, 4, 3);
        strobe(1'b1, 1'b1, '0);
        chk("R11 cur unchanged", int'(cur_level), 0);
        rd(4, d); chk("R11 flag kept", d, 'h33);
        strobe(1'b1, 1'b0, 8'h10);
        chk("R12 ack taken", int'(cur_level), 3);
        rd(4, d); chk("R12 flag kept", d, 'h33);
        strobe(1'b0, 1'b1, '0);
        chk("R12 back to idle", int'(cur_level), 0);
        wr(4, 'h32);
        expect_offer("R5 sw withdraw", 1'b0, 0, 0);
    endtask

    initial begin
        rst = 1'b1; hw_req = '0; reg_we = 1'b0; reg_addr = '0;
        reg_wdata = '0; irq_ack = 1'b0; irq_ret = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_vector();
        t_filters();
        t_ack();
        t_hw_nest();
        t_returns();
        t_empty();
        t_same_cycle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule